// File: doc/BRIEF.md
# Transmit Chunk Processing Buffer

This block sits in the transmit path between an HDLC or transparent-mode framer and the serial line. Data leaves on the line in chunks of 1, 2 or 4 bytes. When the last bit of a chunk goes out, two things happen on the same clock edge. The shift register is reloaded from a write register through a bit-order reversal stage. The framer's next chunk is captured into a read register, which has one copy per requester. On the following edge the write register takes a default copy of the read register, and an interrupt status is raised to both requesters.

The requester that owns the write register can replace the copied value with a post-processed one before the current chunk finishes. The owner is chosen by a select input. After the transmitter is enabled, the line stays idle at ones until the owner has written the first processed chunk. The first chunk is then loaded into the shift register, and shifting begins after the next start-of-slot pulse. The slot counter, the framer and the line driver are outside the block.

Top module: `tx_insert_buf`

## Requirements
- R1: While `tx_en` is low, `line_out` is 1, both read copies read zero and both interrupts are low. Status bits and held data are cleared.
- R2: `chunk_sel` is sampled while disabled: 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 select 4 bytes. On the line, byte 0 (bits 7:0) goes first, then higher bytes, and each byte goes least significant bit first.
- R3: In the first cycle after `tx_en` rises, `hdlc_take` is high and the framer word is captured into the read copies. Nothing is transmitted yet.
- R4: On the edge after every capture, the write register takes the read value unless the owner writes on that edge. Both status bits are set on that edge, whichever requester owns the write register.
- R5: `irq_a`/`irq_b` show their status bit gated by `mask_a`/`mask_b` (1 = masked). A status bit stays set until its `clr_*` input is pulsed, and a new set wins over a clear.
- R6: Only the owner (`owner_sel` 0 = port A, 1 = port B) can change the write register. Writes from the other port, and writes made while disabled or in the first enabled cycle, have no effect on the line.
- R7: From enable until the owner's first write, `line_out` stays 1 whatever `slot_start` does.
- R8: On the edge after the first owner write, the write register is loaded into the shift register. Transmission starts on the first `slot_start` sampled after that load.
- R9: Once running, chunks go out back to back with no idle bits. The reload and the next capture happen on the edge that shifts out the last bit of a chunk.
- R10: A value the owner writes before the current chunk ends replaces the default copy on the line.
- R11: The two read copies always hold the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low acts as transmitter reset |
| chunk_sel | input | 2 | Chunk size code |
| owner_sel | input | 1 | Write register owner: 0 = A, 1 = B |
| slot_start | input | 1 | Start-of-selected-slot pulse |
| hdlc_data | input | 32 | Next chunk from the framer |
| hdlc_take | output | 1 | Framer word consumed on this edge |
| wr_a_en | input | 1 | Requester A write strobe |
| wr_a_data | input | 32 | Requester A write data |
| wr_b_en | input | 1 | Requester B write strobe |
| wr_b_data | input | 32 | Requester B write data |
| rd_a_data | output | 32 | Read register copy for A |
| rd_b_data | output | 32 | Read register copy for B |
| mask_a | input | 1 | Interrupt mask for A |
| mask_b | input | 1 | Interrupt mask for B |
| clr_a | input | 1 | Status clear for A |
| clr_b | input | 1 | Status clear for B |
| irq_a | output | 1 | Interrupt to A |
| irq_b | output | 1 | Interrupt to B |
| line_out | output | 1 | Serial line data |

## Verification
The hardest case to reach from the ports is an owner overwrite that lands between the default copy and the end of the chunk on the line, while the other requester writes junk in the same window. The bench acts as both requesters and responds to each interrupt as it appears. The owner writes the read value XOR a key, and the non-owner writes a fixed junk word. Every chunk on the line is then compared with the keyed or raw framer sequence. Each size, owner and edit/default combination is swept, and one masked run shows that the masked status stays pending.

// File: rtl/tib_pkg.sv
// Shared types and helpers for the transmit chunk processing buffer.
// Assumes chunk sizes are powers of two bytes up to the MAXB parameter.
package tib_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_PRIME,
        ST_WAIT_WR,
        ST_LOAD,
        ST_WAIT_SLOT,
        ST_SHIFT
    } tib_state_e;

    // Map the size select to log2(bytes), clipped to the largest supported size.
    function automatic logic [1:0] size_code(input logic [1:0] sel, input int unsigned max_log);
        logic [1:0] req;
        req = (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
        if ({30'd0, req} > max_log) begin
            req = max_log[1:0];
        end
        return req;
    endfunction

endpackage

// File: rtl/tib_bitrev.sv
// Bit-order reversal stage: reverses the bit order of every byte and the byte
// order of the word. As a result, shifting the result out MSB first sends
// byte 0 first, least significant bit first. Purely combinational.
module tib_bitrev #(
    parameter int NB = 4,
    localparam int DW = NB * 8
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    for (genvar k = 0; k < NB; k++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[(NB - 1 - k) * 8 + (7 - i)] = din[k * 8 + i];
        end
    end

endmodule

// File: rtl/tib_hold_regs.sv
// Read register (one copy per requester) and processor-writable write register.
// The read copies capture the framer word on cap. On the following edge the
// write register takes a default copy, unless an accepted write arrives.
// Assumes wr_en is already qualified by ownership and by the sequencer.
module tib_hold_regs #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          cap,
    input  logic [DW-1:0] cap_word,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_a_q,
    output logic [DW-1:0] rd_b_q,
    output logic [DW-1:0] wr_q,
    output logic          copy_evt
);

    logic cap_pend;

    // Capture the framer word into both read copies together.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            rd_a_q <= '0;
            rd_b_q <= '0;
        end else if (cap) begin
            rd_a_q <= cap_word;
            rd_b_q <= cap_word;
        end
    end

    // Remember that a capture happened, so the copy occurs one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            cap_pend <= 1'b0;
        end else begin
            cap_pend <= cap;
        end
    end

    // Write register: an owner write has priority over the default copy.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            wr_q <= '0;
        end else if (wr_en) begin
            wr_q <= wr_data;
        end else if (cap_pend) begin
            wr_q <= rd_a_q;
        end
    end

    assign copy_evt = cap_pend;

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && tx_en) |=> (rd_a_q == $past(cap_word)));

    assert_default_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pend && !wr_en && tx_en) |=> (wr_q == $past(rd_a_q)));

    assert_owner_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_en) |=> (wr_q == $past(wr_data)));

    assert_copies_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_q == rd_b_q);

endmodule

// File: rtl/tib_irq_stat.sv
// Per-requester sticky interrupt status with mask. A set event reaches every
// requester, and a set wins over a clear in the same cycle. Status is cleared
// while the transmitter is disabled.
module tib_irq_stat #(
    parameter int NREQ = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            set,
    input  logic [NREQ-1:0] mask,
    input  logic [NREQ-1:0] clr,
    output logic [NREQ-1:0] irq
);

    logic [NREQ-1:0] stat;

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        // Sticky status bit for requester g.
        always_ff @(posedge clk) begin
            if (!rst_n || !tx_en) begin
                stat[g] <= 1'b0;
            end else if (set) begin
                stat[g] <= 1'b1;
            end else if (clr[g]) begin
                stat[g] <= 1'b0;
            end
        end

        assign irq[g] = stat[g] & ~mask[g];

        assert_status_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (set && tx_en) |=> stat[g]);

        assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[g] && !clr[g] && tx_en) |=> stat[g]);
    end

endmodule

// File: rtl/tib_line_seq.sv
// Line sequencer: start-up order, slot alignment, bit counter and shift register.
// After enable it primes the read register, waits for the owner's first write,
// loads the shift register and waits for a slot start. After that it shifts one
// bit per clock and reloads on every chunk boundary.
// Assumes load_word is already bit-reversed, so it is shifted out MSB first.
module tib_line_seq
    import tib_pkg::*;
#(
    parameter int MAXB = 4,
    localparam int DW = MAXB * 8,
    localparam int CW = $clog2(DW),
    localparam int LOGMAX = $clog2(MAXB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic [1:0]    chunk_sel,
    input  logic          own_wr,
    input  logic          slot_start,
    input  logic [DW-1:0] load_word,
    output logic          line_out,
    output logic          hdlc_take,
    output logic          wr_open
);

    tib_state_e    state_q, state_d;
    logic [1:0]    size_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_bit;
    logic [DW-1:0] sreg_q;
    logic          chunk_end;

    assign last_bit  = CW'((32'd8 << size_q) - 32'd1);
    assign chunk_end = (state_q == ST_SHIFT) && (cnt_q == last_bit);

    // Next-state logic for the start-up and steady-state sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:       state_d = ST_PRIME;
            ST_PRIME:     state_d = ST_WAIT_WR;
            ST_WAIT_WR:   if (own_wr) state_d = ST_LOAD;
            ST_LOAD:      state_d = ST_WAIT_SLOT;
            ST_WAIT_SLOT: if (slot_start) state_d = ST_SHIFT;
            ST_SHIFT:     state_d = ST_SHIFT;
            default:      state_d = ST_OFF;
        endcase
    end

    // State register; a disabled transmitter returns to the off state.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch the chunk size while off, so it stays fixed during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= 2'd0;
        end else if (state_q == ST_OFF) begin
            size_q <= size_code(chunk_sel, LOGMAX);
        end
    end

    // Shift register and bit counter, with a reload at each chunk boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (state_q == ST_LOAD || chunk_end) begin
            sreg_q <= load_word;
            cnt_q  <= '0;
        end else if (state_q == ST_SHIFT) begin
            sreg_q <= {sreg_q[DW-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign hdlc_take = tx_en && (state_q == ST_PRIME || state_q == ST_LOAD || chunk_end);
    assign wr_open   = tx_en && (state_q != ST_OFF) && (state_q != ST_PRIME);
    assign line_out  = (state_q == ST_SHIFT) ? sreg_q[DW-1] : 1'b1;

    assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (line_out && !hdlc_take));

    assert_idle_until_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_WR && tx_en) |=> line_out);

    assert_wait_for_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SLOT && tx_en && !slot_start) |=> (state_q == ST_WAIT_SLOT));

    assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_end && tx_en) |=> (state_q == ST_SHIFT && cnt_q == '0
                                  && line_out == $past(load_word[DW-1])));

endmodule

// File: rtl/tx_insert_buf.sv
// Transmit chunk processing buffer, top level.
// It routes the owner's write port to the write register and reverses the
// write register into the shift register. It also fans the copy event out as
// interrupt status to both requesters.
// Assumes the framer holds hdlc_data valid until hdlc_take is seen on an edge.
module tx_insert_buf #(
    parameter int MAXB = 4,
    localparam int DW = MAXB * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic [1:0]    chunk_sel,
    input  logic          owner_sel,
    input  logic          slot_start,
    input  logic [DW-1:0] hdlc_data,
    output logic          hdlc_take,
    input  logic          wr_a_en,
    input  logic [DW-1:0] wr_a_data,
    input  logic          wr_b_en,
    input  logic [DW-1:0] wr_b_data,
    output logic [DW-1:0] rd_a_data,
    output logic [DW-1:0] rd_b_data,
    input  logic          mask_a,
    input  logic          mask_b,
    input  logic          clr_a,
    input  logic          clr_b,
    output logic          irq_a,
    output logic          irq_b,
    output logic          line_out
);

    logic          wr_open;
    logic          own_en;
    logic          own_wr;
    logic [DW-1:0] own_data;
    logic [DW-1:0] wr_q;
    logic [DW-1:0] wr_rev;
    logic          copy_evt;
    logic [1:0]    irq_vec;

    // Select the owning requester's write port; the other port is ignored.
    always_comb begin
        own_en   = owner_sel ? wr_b_en : wr_a_en;
        own_data = owner_sel ? wr_b_data : wr_a_data;
    end

    assign own_wr = own_en && wr_open;

    tib_line_seq #(.MAXB(MAXB)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .chunk_sel  (chunk_sel),
        .own_wr     (own_wr),
        .slot_start (slot_start),
        .load_word  (wr_rev),
        .line_out   (line_out),
        .hdlc_take  (hdlc_take),
        .wr_open    (wr_open)
    );

    tib_hold_regs #(.DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .cap      (hdlc_take),
        .cap_word (hdlc_data),
        .wr_en    (own_wr),
        .wr_data  (own_data),
        .rd_a_q   (rd_a_data),
        .rd_b_q   (rd_b_data),
        .wr_q     (wr_q),
        .copy_evt (copy_evt)
    );

    tib_bitrev #(.NB(MAXB)) u_rev (
        .din  (wr_q),
        .dout (wr_rev)
    );

    tib_irq_stat #(.NREQ(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_en (tx_en),
        .set   (copy_evt),
        .mask  ({mask_b, mask_a}),
        .clr   ({clr_b, clr_a}),
        .irq   (irq_vec)
    );

    assign irq_a = irq_vec[0];
    assign irq_b = irq_vec[1];

    assert_foreign_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !own_wr && !copy_evt) |=> $stable(wr_q));

endmodule

// File: tb/test_tx_insert_buf.sv
`timescale 1ns/1ps
module test_tx_insert_buf;
    localparam int MAXB = 4;
    localparam int DW = 32;
    localparam int NCH = 5;
    localparam logic [31:0] KEY  = 32'hA5C3_5A3C;
    localparam logic [31:0] JUNK = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, tx_en = 1'b0, owner_sel = 1'b0, slot_start = 1'b0;
    logic [1:0] chunk_sel = 2'd0;
    logic [DW-1:0] hdlc_data, wr_a_data = '0, wr_b_data = '0, rd_a_data, rd_b_data;
    logic wr_a_en = 1'b0, wr_b_en = 1'b0, mask_a = 1'b0, mask_b = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
    logic hdlc_take, irq_a, irq_b, line_out;

    tx_insert_buf #(.MAXB(MAXB)) i_tx_insert_buf (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .chunk_sel(chunk_sel), .owner_sel(owner_sel),
        .slot_start(slot_start), .hdlc_data(hdlc_data), .hdlc_take(hdlc_take),
        .wr_a_en(wr_a_en), .wr_a_data(wr_a_data), .wr_b_en(wr_b_en), .wr_b_data(wr_b_data),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .mask_a(mask_a), .mask_b(mask_b),
        .clr_a(clr_a), .clr_b(clr_b), .irq_a(irq_a), .irq_b(irq_b), .line_out(line_out));

    // Framer model: a word sequence that advances on every take.
    int take_cnt = 0;
    always @(posedge clk) if (hdlc_take) take_cnt <= take_cnt + 1;

    function automatic logic [31:0] gen(input int k);
        return (32'h9E37_79B9 * (k + 1)) ^ (32'h0F1E_2D3C + k);
    endfunction
    assign hdlc_data = gen(take_cnt);

    int total = 0, bad = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] sel, input logic own, input logic edit, input logic mo);
        int nb;
        int base;
        logic done;
        logic [31:0] msk;
        nb = ((sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4) * 8;
        msk = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
        @(negedge clk);
        tx_en = 1'b0; chunk_sel = sel; owner_sel = own;
        mask_a = mo && own; mask_b = mo && !own;
        // R6: owner write while disabled must not matter
        if (own) begin wr_b_en = 1'b1; wr_b_data = JUNK; end else begin wr_a_en = 1'b1; wr_a_data = JUNK; end
        @(negedge clk);
        wr_a_en = 1'b0; wr_b_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(line_out === 1'b1, "R1 line idle", {31'd0, line_out}, 32'd1);
        chk(rd_a_data == 0 && rd_b_data == 0, "R1 read cleared", rd_a_data, 32'd0);
        chk(!irq_a && !irq_b, "R1 irq low", {30'd0, irq_b, irq_a}, 32'd0);
        base = take_cnt;
        tx_en = 1'b1;
        @(negedge clk);
        chk(hdlc_take === 1'b1 && line_out === 1'b1, "R3 prime take", {30'd0, hdlc_take, line_out}, 32'd3);
        @(negedge clk);
        chk(rd_a_data == gen(base), "R3 capture", rd_a_data, gen(base));
        chk(rd_b_data == rd_a_data, "R11 copies", rd_b_data, rd_a_data);
        for (int i = 0; i < 10; i++) begin
            slot_start = (i % 3 == 0);
            @(negedge clk);
            chk(line_out === 1'b1, "R7 idle before write", {31'd0, line_out}, 32'd1);
        end
        slot_start = 1'b0;
        chk((own ? irq_b : irq_a) === 1'b1, "R4 owner irq", {31'd0, own ? irq_b : irq_a}, 32'd1);
        chk((own ? irq_a : irq_b) === !mo, "R4 R5 other irq", {31'd0, own ? irq_a : irq_b}, {31'd0, !mo});
        // R6: non-owner write followed by slot pulses starts nothing
        if (own) begin wr_a_en = 1'b1; wr_a_data = JUNK; end else begin wr_b_en = 1'b1; wr_b_data = JUNK; end
        @(negedge clk);
        wr_a_en = 1'b0; wr_b_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            slot_start = (i == 1);
            @(negedge clk);
            chk(line_out === 1'b1, "R6 foreign write ignored", {31'd0, line_out}, 32'd1);
        end
        slot_start = 1'b0;
        // First owner write
        if (own) begin
            wr_b_en = 1'b1; wr_b_data = edit ? (rd_b_data ^ KEY) : rd_b_data;
        end else begin
            wr_a_en = 1'b1; wr_a_data = edit ? (rd_a_data ^ KEY) : rd_a_data;
        end
        clr_a = 1'b1; clr_b = 1'b1;
        @(negedge clk);
        wr_a_en = 1'b0; wr_b_en = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk(line_out === 1'b1, "R8 wait for slot", {31'd0, line_out}, 32'd1);
        end
        done = 1'b0;
        fork
            begin
                slot_start = 1'b1;
                @(negedge clk);
                slot_start = 1'b0;
                for (int j = 0; j < NCH; j++) begin
                    logic [31:0] got, exp;
                    got = '0;
                    for (int b = 0; b < nb; b++) begin
                        got[b] = line_out;
                        @(negedge clk);
                    end
                    exp = (edit ? (gen(base + j) ^ KEY) : gen(base + j)) & msk;
                    chk(got == exp, "R2 R9 R10 chunk on line", got, exp);
                end
                done = 1'b1;
            end
            begin
                while (!done) begin
                    logic oi, xi;
                    oi = own ? irq_b : irq_a;
                    xi = own ? irq_a : irq_b;
                    wr_a_en = 1'b0; wr_b_en = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
                    if (oi) begin
                        chk(xi === !mo, "R4 R5 both raised", {31'd0, xi}, {31'd0, !mo});
                        if (own) begin
                            clr_b = 1'b1;
                            if (edit) begin wr_b_en = 1'b1; wr_b_data = rd_b_data ^ KEY; end
                        end else begin
                            clr_a = 1'b1;
                            if (edit) begin wr_a_en = 1'b1; wr_a_data = rd_a_data ^ KEY; end
                        end
                    end
                    if (xi && !mo) begin
                        if (own) begin wr_a_en = 1'b1; wr_a_data = JUNK; clr_a = 1'b1; end
                        else begin wr_b_en = 1'b1; wr_b_data = JUNK; clr_b = 1'b1; end
                    end
                    @(negedge clk);
                end
                wr_a_en = 1'b0; wr_b_en = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
            end
        join
        if (mo) begin
            mask_a = 1'b0; mask_b = 1'b0;
            #1;
            chk((own ? irq_a : irq_b) === 1'b1, "R5 masked status pending", {31'd0, own ? irq_a : irq_b}, 32'd1);
        end
        @(negedge clk);
        tx_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(line_out === 1'b1 && !irq_a && !irq_b, "R1 reset state", {29'd0, irq_b, irq_a, line_out}, 32'd1);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 2; o++) begin
                for (int e = 0; e < 2; e++) begin
                    run(s[1:0], o[0], e[0], (s == 1) && (e == 1));
                end
            end
        end
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule